// File: doc/BRIEF.md
# Trace Window Sync Detector and Flow Compressor

This block watches a processor's per-clock trace status: a 3-bit instruction-status code and a 2-bit flush count. It also takes a separate bus-monitor input that delivers 30-bit show-cycle addresses. From these it works out when the trace window opens and closes. Both events are marked by a synchronization code, and that code is only recognised after certain earlier codes. It classifies the starting point of the trace. While the window is open, it turns the per-clock stream into a short list of flow-change records, each carrying the number of sequential instructions that ran since the previous flow change.

Show-cycle addresses can reach the bus several clocks after the status code that announced them. They are therefore queued in their own FIFO, apart from the status decode. The record output stage pairs each record that needs an address with the oldest queued address. It presents records on a valid/ready handshake.

Instruction-status codes: 000 no instruction, 001 sequential instruction, 010 branch not taken, 011 synchronization report or sequential instruction, 101 taken indirect branch, 110 taken direct branch, 100 and 111 no instruction. Record type codes on `rec_type`: 0 start at sequential instruction, 1 start at direct branch target, 2 start at indirect branch target, 3 direct branch taken, 4 branch not taken, 5 indirect flow change, 6 window end.

Top module: `trace_window_compressor`

## Requirements
- R1: A synchronous active-high reset leaves the window closed with `win_open`=0, `rec_valid`=0, `fifo_ovf`=0, both queues empty and the sequential count at zero.
- R2: Code 011 is a synchronization report only when the code on the previous clock was 000, 001 or 010. In any other case it counts as one sequential instruction. A report while the window is closed opens it (`win_open`=1 on the next cycle).
- R3: After the opening report, codes other than 001, 110 and 101 are ignored. The first of these three codes emits a start record of type 0, 1 or 2 respectively, with count 0 and the oldest queued show address.
- R4: While the window is open, code 110 emits type 3 and code 010 emits type 4, both with address 0. Code 101 emits type 5 with the oldest queued show address. Each record carries the pending sequential count, and that count then restarts from zero. Codes 001 and non-synchronizing 011 each add one to the count.
- R5: The flush field value is subtracted from the pending count in the same clock, floored at zero. This happens before that clock's increment or record.
- R6: A synchronization report while the window is open emits a type 6 record with the pending count and closes the window. Show addresses offered in that clock, and while the window is closed, are discarded.
- R7: The sequential count is 16 bits wide and saturates at 65535.
- R8: Show addresses are queued independently of the status decode. A record that needs an address waits for one, even if it arrives several clocks later, and records leave in the order their codes were seen.
- R9: While `rec_valid` is high and `rec_ready` is low, the record fields hold steady. No record is lost or duplicated.
- R10: A push into a full show-address queue (depth 4) or a full record queue discards the entry and sets `fifo_ovf`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| istat | input | 3 | Instruction-status code for this clock |
| fstat | input | 2 | Number of recently reported instructions cancelled this clock |
| show_valid | input | 1 | A show-cycle address is present on `show_addr` |
| show_addr | input | 30 | Show-cycle address from the bus monitor |
| rec_ready | input | 1 | Downstream accepts the current record |
| rec_valid | output | 1 | A record is presented |
| rec_type | output | 3 | Record type code |
| rec_count | output | 16 | Sequential instructions before this record |
| rec_addr | output | 30 | Address for start and indirect records, else zero |
| win_open | output | 1 | Trace window is armed or open |
| fifo_ovf | output | 1 | Sticky queue overflow flag |

## Verification
Some behaviours are checked by assertions on every cycle. These are: a window opens only after a qualifying synchronization pair, an end record is always followed by a closed window, a flow-change record is always followed by a restarted count, record fields hold under backpressure, the overflow flag is sticky, and no queue is popped while empty. Other behaviours need the directed scenarios. These are: the exact record sequence and counts, the arithmetic of flush subtraction and saturation, the alias of 011 as a sequential instruction, pairing of late-arriving addresses with the right records, and discarding of addresses at and after the closing report.

// File: rtl/twc_pkg.sv
package twc_pkg;

  localparam logic [2:0] IS_NONE = 3'b000;
  localparam logic [2:0] IS_SEQ  = 3'b001;
  localparam logic [2:0] IS_NT   = 3'b010;
  localparam logic [2:0] IS_SYNC = 3'b011;
  localparam logic [2:0] IS_IND  = 3'b101;
  localparam logic [2:0] IS_DIR  = 3'b110;

  typedef enum logic [2:0] {
    REC_START_SEQ = 3'd0,
    REC_START_DIR = 3'd1,
    REC_START_IND = 3'd2,
    REC_DIRECT    = 3'd3,
    REC_NOT_TAKEN = 3'd4,
    REC_INDIRECT  = 3'd5,
    REC_END       = 3'd6
  } rec_kind_e;

  typedef enum logic [1:0] {
    W_CLOSED = 2'd0,
    W_ARMED  = 2'd1,
    W_OPEN   = 2'd2
  } win_state_e;

  function automatic logic needs_addr(rec_kind_e k);
    return (k == REC_START_SEQ) || (k == REC_START_DIR) ||
           (k == REC_START_IND) || (k == REC_INDIRECT);
  endfunction

endpackage

// File: rtl/twc_fifo.sv
module twc_fifo #(
  parameter int W     = 30,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         ovf
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wr_q, rd_q;
  logic         full;

  assign empty = (wr_q == rd_q);
  assign full  = (wr_q[AW] != rd_q[AW]) && (wr_q[AW-1:0] == rd_q[AW-1:0]);
  assign dout  = mem[rd_q[AW-1:0]];

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push && !full) mem[wr_q[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q <= '0;
      rd_q <= '0;
      ovf  <= 1'b0;
    end else begin
      if (push && !full) wr_q <= wr_q + 1'b1;
      if (push && full)  ovf  <= 1'b1;
      if (pop && !empty) rd_q <= rd_q + 1'b1;
    end
  end

  // R8: the consumer never pops an empty queue
  a_r8_pop_nonempty: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty) else $error("pop on empty queue");

  // R10: overflow flag is sticky until reset
  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf) else $error("overflow flag dropped");

endmodule

// File: rtl/twc_decoder.sv
module twc_decoder
  import twc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       istat_i,
  input  logic [1:0]       fstat_i,
  output logic             ev_push_o,
  output rec_kind_e        ev_kind_o,
  output logic [CNT_W-1:0] ev_count_o,
  output logic             addr_accept_o,
  output logic             win_open_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  win_state_e       state_q, state_d;
  logic [2:0]       prev_q;
  logic [CNT_W-1:0] cnt_q, cnt_d, floored, bumped, fl_ext;
  logic             sync;

  assign sync    = (istat_i == IS_SYNC) && (prev_q <= 3'b010);
  assign fl_ext  = CNT_W'(fstat_i);
  assign floored = (cnt_q > fl_ext) ? (cnt_q - fl_ext) : '0;
  assign bumped  = (floored == CNT_MAX) ? CNT_MAX : floored + 1'b1;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    ev_push_o  = 1'b0;
    ev_kind_o  = REC_END;
    ev_count_o = floored;
    unique case (state_q)
      W_CLOSED: begin
        if (sync) begin
          state_d = W_ARMED;
          cnt_d   = '0;
        end
      end
      W_ARMED: begin
        ev_count_o = '0;
        cnt_d      = '0;
        if (istat_i == IS_SEQ || istat_i == IS_DIR || istat_i == IS_IND) begin
          ev_push_o = 1'b1;
          state_d   = W_OPEN;
          ev_kind_o = (istat_i == IS_SEQ) ? REC_START_SEQ :
                      (istat_i == IS_DIR) ? REC_START_DIR : REC_START_IND;
        end
      end
      W_OPEN: begin
        cnt_d = floored;
        if (sync) begin
          ev_push_o = 1'b1;
          ev_kind_o = REC_END;
          state_d   = W_CLOSED;
          cnt_d     = '0;
        end else begin
          unique case (istat_i)
            IS_SEQ, IS_SYNC: cnt_d = bumped;
            IS_NT: begin
              ev_push_o = 1'b1; ev_kind_o = REC_NOT_TAKEN; cnt_d = '0;
            end
            IS_DIR: begin
              ev_push_o = 1'b1; ev_kind_o = REC_DIRECT; cnt_d = '0;
            end
            IS_IND: begin
              ev_push_o = 1'b1; ev_kind_o = REC_INDIRECT; cnt_d = '0;
            end
            default: cnt_d = floored;
          endcase
        end
      end
      default: state_d = W_CLOSED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= W_CLOSED;
      prev_q  <= 3'b111;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      prev_q  <= istat_i;
      cnt_q   <= cnt_d;
    end
  end

  assign win_open_o    = (state_q != W_CLOSED);
  assign addr_accept_o = (state_q != W_CLOSED) && !(state_q == W_OPEN && sync);

  // R2: a window opens only after 011 preceded by 000, 001 or 010
  a_r2_open_needs_pair: assert property (@(posedge clk) disable iff (rst)
    $rose(win_open_o) |-> ($past(istat_i) == IS_SYNC && $past(prev_q) <= 3'b010))
    else $error("window opened without qualifying report");

  // R6: an end record closes the window
  a_r6_end_closes: assert property (@(posedge clk) disable iff (rst)
    (ev_push_o && ev_kind_o == REC_END) |=> !win_open_o)
    else $error("window still open after end record");

  // R4: a flow-change record restarts the sequential count
  a_r4_count_restart: assert property (@(posedge clk) disable iff (rst)
    (ev_push_o && (ev_kind_o == REC_DIRECT || ev_kind_o == REC_NOT_TAKEN ||
                   ev_kind_o == REC_INDIRECT)) |=> (cnt_q <= 1))
    else $error("count not restarted after flow change");

endmodule

// File: rtl/twc_emitter.sv
module twc_emitter
  import twc_pkg::*;
#(
  parameter int ADDR_W = 30,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_empty,
  input  rec_kind_e         ev_kind,
  input  logic [CNT_W-1:0]  ev_count,
  input  logic              addr_empty,
  input  logic [ADDR_W-1:0] addr_data,
  input  logic              rec_ready,
  output logic              ev_pop,
  output logic              addr_pop,
  output logic              rec_valid,
  output logic [2:0]        rec_type,
  output logic [CNT_W-1:0]  rec_count,
  output logic [ADDR_W-1:0] rec_addr
);
  logic need, can_load;

  assign need     = needs_addr(ev_kind);
  assign can_load = (!rec_valid || rec_ready) && !ev_empty && (!need || !addr_empty);
  assign ev_pop   = can_load;
  assign addr_pop = can_load && need;

  always_ff @(posedge clk) begin
    if (rst) begin
      rec_valid <= 1'b0;
      rec_type  <= '0;
      rec_count <= '0;
      rec_addr  <= '0;
    end else if (can_load) begin
      rec_valid <= 1'b1;
      rec_type  <= ev_kind;
      rec_count <= ev_count;
      rec_addr  <= need ? addr_data : '0;
    end else if (rec_ready) begin
      rec_valid <= 1'b0;
    end
  end

  // R9: a stalled record holds all its fields
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && !rec_ready) |=>
      (rec_valid && $stable(rec_type) && $stable(rec_count) && $stable(rec_addr)))
    else $error("record changed under backpressure");

endmodule

// File: rtl/trace_window_compressor.sv
module trace_window_compressor
  import twc_pkg::*;
#(
  parameter int ADDR_W     = 30,
  parameter int CNT_W      = 16,
  parameter int ADDR_DEPTH = 4,
  parameter int EV_DEPTH   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        istat,
  input  logic [1:0]        fstat,
  input  logic              show_valid,
  input  logic [ADDR_W-1:0] show_addr,
  input  logic              rec_ready,
  output logic              rec_valid,
  output logic [2:0]        rec_type,
  output logic [CNT_W-1:0]  rec_count,
  output logic [ADDR_W-1:0] rec_addr,
  output logic              win_open,
  output logic              fifo_ovf
);
  localparam int EV_W = 3 + CNT_W;

  logic              ev_push, ev_pop, ev_empty, ev_ovf;
  rec_kind_e         ev_kind_in;
  logic [CNT_W-1:0]  ev_count_in;
  logic [EV_W-1:0]   ev_dout;
  logic              addr_accept, addr_pop, addr_empty, addr_ovf;
  logic [ADDR_W-1:0] addr_dout;

  twc_decoder #(.CNT_W(CNT_W)) u_dec (
    .clk(clk), .rst(rst), .istat_i(istat), .fstat_i(fstat),
    .ev_push_o(ev_push), .ev_kind_o(ev_kind_in), .ev_count_o(ev_count_in),
    .addr_accept_o(addr_accept), .win_open_o(win_open)
  );

  twc_fifo #(.W(ADDR_W), .DEPTH(ADDR_DEPTH)) u_addr_q (
    .clk(clk), .rst(rst), .push(show_valid && addr_accept), .din(show_addr),
    .pop(addr_pop), .dout(addr_dout), .empty(addr_empty), .ovf(addr_ovf)
  );

  twc_fifo #(.W(EV_W), .DEPTH(EV_DEPTH)) u_ev_q (
    .clk(clk), .rst(rst), .push(ev_push), .din({ev_kind_in, ev_count_in}),
    .pop(ev_pop), .dout(ev_dout), .empty(ev_empty), .ovf(ev_ovf)
  );

  twc_emitter #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_emit (
    .clk(clk), .rst(rst), .ev_empty(ev_empty),
    .ev_kind(rec_kind_e'(ev_dout[EV_W-1:CNT_W])), .ev_count(ev_dout[CNT_W-1:0]),
    .addr_empty(addr_empty), .addr_data(addr_dout), .rec_ready(rec_ready),
    .ev_pop(ev_pop), .addr_pop(addr_pop), .rec_valid(rec_valid),
    .rec_type(rec_type), .rec_count(rec_count), .rec_addr(rec_addr)
  );

  assign fifo_ovf = addr_ovf | ev_ovf;

endmodule

// File: tb/trace_window_compressor_bench.sv
`timescale 1ns/1ps
module trace_window_compressor_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  istat = 3'b100;
  logic [1:0]  fstat = 2'd0;
  logic        show_valid = 1'b0;
  logic [29:0] show_addr = '0;
  logic        rec_ready = 1'b1;
  logic        rec_valid, win_open, fifo_ovf;
  logic [2:0]  rec_type;
  logic [15:0] rec_count;
  logic [29:0] rec_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [2:0]  got_t[$];
  logic [15:0] got_c[$];
  logic [29:0] got_a[$];

  trace_window_compressor u_trace_window_compressor (
    .clk(clk), .rst(rst), .istat(istat), .fstat(fstat),
    .show_valid(show_valid), .show_addr(show_addr), .rec_ready(rec_ready),
    .rec_valid(rec_valid), .rec_type(rec_type), .rec_count(rec_count),
    .rec_addr(rec_addr), .win_open(win_open), .fifo_ovf(fifo_ovf)
  );

  always #5 clk = ~clk;

  // capture accepted records away from the clock edge
  always @(negedge clk) begin
    if (!rst && rec_valid && rec_ready) begin
      got_t.push_back(rec_type);
      got_c.push_back(rec_count);
      got_a.push_back(rec_addr);
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic [2:0] i, input logic [1:0] f = 2'd0,
                     input logic sv = 1'b0, input logic [29:0] a = '0);
    istat = i; fstat = f; show_valid = sv; show_addr = a;
    @(posedge clk); #2;
  endtask

  task automatic do_reset();
    rst = 1'b1; istat = 3'b100; fstat = 0; show_valid = 0; rec_ready = 1;
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    got_t.delete(); got_c.delete(); got_a.delete();
  endtask

  task automatic drain();
    repeat (12) cyc(3'b100);
  endtask

  task automatic exp_rec(input logic [2:0] k, input logic [15:0] c,
                         input logic [29:0] a, input string req);
    logic [2:0] t; logic [15:0] n; logic [29:0] ad;
    if (got_t.size() == 0) begin
      chk(1'b0, req, "missing record type", 0, k);
      return;
    end
    t = got_t.pop_front(); n = got_c.pop_front(); ad = got_a.pop_front();
    chk(t == k, req, "record type", t, k);
    chk(n == c, req, "record count", n, c);
    chk(ad == a, req, "record addr", ad, a);
  endtask

  task automatic exp_none(input string req);
    chk(got_t.size() == 0, req, "extra records", got_t.size(), 0);
  endtask

  task automatic t_reset();
    do_reset();
    chk(rec_valid == 0, "R1", "rec_valid", rec_valid, 0);
    chk(win_open == 0, "R1", "win_open", win_open, 0);
    chk(fifo_ovf == 0, "R1", "fifo_ovf", fifo_ovf, 0);
  endtask

  task automatic t_basic();
    cyc(3'b000); cyc(3'b011);
    chk(win_open == 1, "R2", "win_open after report", win_open, 1);
    cyc(3'b001, 0, 1, 30'h1000);
    repeat (3) cyc(3'b001);
    cyc(3'b110);
    repeat (2) cyc(3'b001);
    cyc(3'b010);
    cyc(3'b001);
    cyc(3'b101, 0, 1, 30'h2000);
    repeat (2) cyc(3'b001);
    cyc(3'b000); cyc(3'b011);
    chk(win_open == 0, "R6", "win_open after end", win_open, 1'b0);
    drain();
    exp_rec(3'd0, 0, 30'h1000, "R3");
    exp_rec(3'd3, 3, 0, "R4");
    exp_rec(3'd4, 2, 0, "R4");
    exp_rec(3'd5, 1, 30'h2000, "R4");
    exp_rec(3'd6, 2, 0, "R6");
    exp_none("R4");
  endtask

  task automatic t_alias();
    cyc(3'b100); cyc(3'b011);
    chk(win_open == 0, "R2", "011 after 100 opened window", win_open, 0);
    cyc(3'b011);
    chk(win_open == 0, "R2", "011 after 011 opened window", win_open, 0);
    cyc(3'b000); cyc(3'b011);
    cyc(3'b110, 0, 1, 30'h3000);
    cyc(3'b011); cyc(3'b011);
    chk(win_open == 1, "R2", "011 after 110 closed window", win_open, 1);
    cyc(3'b010);
    cyc(3'b011);
    drain();
    exp_rec(3'd1, 0, 30'h3000, "R3");
    exp_rec(3'd4, 2, 0, "R2");
    exp_rec(3'd6, 0, 0, "R2");
    exp_none("R2");
  endtask

  task automatic t_flush();
    cyc(3'b000); cyc(3'b011);
    cyc(3'b010); cyc(3'b100); cyc(3'b000);   // ignored while armed
    cyc(3'b101, 0, 1, 30'h4000);
    repeat (3) cyc(3'b001);
    cyc(3'b001, 2'd2);
    cyc(3'b110, 2'd1);
    cyc(3'b000, 2'd3);
    cyc(3'b010);
    cyc(3'b001); cyc(3'b000); cyc(3'b011);
    drain();
    exp_rec(3'd2, 0, 30'h4000, "R3");
    exp_rec(3'd3, 1, 0, "R5");
    exp_rec(3'd4, 0, 0, "R5");
    exp_rec(3'd6, 1, 0, "R5");
    exp_none("R5");
  endtask

  task automatic t_delay_bp();
    rec_ready = 1'b0;
    cyc(3'b000); cyc(3'b011);
    cyc(3'b001);
    cyc(3'b001);
    cyc(3'b001, 0, 1, 30'h5000);
    cyc(3'b101);
    cyc(3'b010);
    cyc(3'b000, 0, 1, 30'h6000);
    cyc(3'b000); cyc(3'b011);
    repeat (3) cyc(3'b100);
    chk(rec_valid == 1, "R9", "rec_valid stalled", rec_valid, 1);
    chk(rec_type == 3'd0, "R9", "stalled type", rec_type, 0);
    chk(rec_addr == 30'h5000, "R8", "stalled addr", rec_addr, 30'h5000);
    repeat (4) cyc(3'b100);
    chk(rec_type == 3'd0 && rec_addr == 30'h5000, "R9", "held type", rec_type, 0);
    exp_none("R9");
    rec_ready = 1'b1;
    drain();
    exp_rec(3'd0, 0, 30'h5000, "R8");
    exp_rec(3'd5, 2, 30'h6000, "R8");
    exp_rec(3'd4, 0, 0, "R8");
    exp_rec(3'd6, 0, 0, "R9");
    exp_none("R9");
  endtask

  task automatic t_stop();
    cyc(3'b100, 0, 1, 30'h7777);
    cyc(3'b000);
    cyc(3'b011, 0, 1, 30'h8888);
    cyc(3'b001, 0, 1, 30'h9000);
    cyc(3'b000);
    cyc(3'b011, 0, 1, 30'hAAAA);
    cyc(3'b100, 0, 1, 30'hBBBB);
    cyc(3'b000); cyc(3'b011);
    cyc(3'b110, 0, 1, 30'hC000);
    cyc(3'b000); cyc(3'b011);
    drain();
    exp_rec(3'd0, 0, 30'h9000, "R6");
    exp_rec(3'd6, 0, 0, "R6");
    exp_rec(3'd1, 0, 30'hC000, "R6");
    exp_rec(3'd6, 0, 0, "R6");
    exp_none("R6");
  endtask

  task automatic t_ovf();
    cyc(3'b000); cyc(3'b011);
    for (int k = 0; k < 4; k++) cyc(3'b000, 0, 1, 30'(k));
    chk(fifo_ovf == 0, "R10", "ovf after 4", fifo_ovf, 0);
    cyc(3'b000, 0, 1, 30'h55);
    chk(fifo_ovf == 1, "R10", "ovf after 5", fifo_ovf, 1);
    repeat (3) cyc(3'b100);
    chk(fifo_ovf == 1, "R10", "ovf sticky", fifo_ovf, 1);
    do_reset();
    chk(fifo_ovf == 0, "R1", "ovf after reset", fifo_ovf, 0);
    chk(win_open == 0, "R1", "win_open after reset", win_open, 0);
  endtask

  task automatic t_sat();
    cyc(3'b000); cyc(3'b011);
    cyc(3'b001, 0, 1, 30'hD000);
    for (int k = 0; k < 70000; k++) cyc(3'b001);
    cyc(3'b010);
    cyc(3'b000); cyc(3'b011);
    drain();
    exp_rec(3'd0, 0, 30'hD000, "R7");
    exp_rec(3'd4, 16'hFFFF, 0, "R7");
    exp_rec(3'd6, 0, 0, "R7");
    exp_none("R7");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run incomplete, actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_alias();
    t_flush();
    t_delay_bp();
    t_stop();
    t_ovf();
    t_sat();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule